// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block decodes one 16-bit instruction halfword into the fields an execution stage needs: the operand form, a widened opcode, up to six register indices, an immediate widened by any pending prefix, a shift amount taken from the last register field, and an illegal flag. The general register file holds 12 registers. The register fields of the register-operand forms are packed in base 3, so a plain bit slice cannot recover them; the decoder unpacks them arithmetically.

Two prefix words carry state from one instruction to the next. The immediate prefix holds 10 bits that are placed above the immediate of the next immediate-carrying word, and several such prefixes chain. The operand prefix holds a packed two- or three-register field that is appended to the operands of the next register-form word, which gives up to six operands. Decode outputs follow the input word in the same cycle. Prefix state moves only on a clock edge with `insn_valid_i` high.

Top module: `insn16_decode`

## Requirements
- R1: `form_o` is chosen by `insn_i[15:12]`. Patterns 00xx, 0100, 10xx and 1100 are register forms: 0 = three operands, 1 = two, 2 = one, 3 = zero. 0101 and 0110 give 4 (register plus 6-bit immediate, any of 16 registers). 0111 gives 5 (the same, limited to 12 registers). 1101 and 1110 give 6 (10-bit immediate). 1111 with bits 11:10 = 00 gives 7 (immediate prefix). 1111 with bit 11 = 1 gives 8 (operand prefix). Anything else gives 9 and raises `illegal_o`.
- R2: In a register-form word whose bits 10:6 hold v < 27, three registers a, b and c are decoded. Their high parts are v div 9, (v div 3) mod 3 and v mod 3. Their low bits are bits 5:4, 3:2 and 1:0. `regs_o` carries a, b, c in slots 0, 1, 2, `nregs_o` = 3, and `opcode_o` = {bits 15:11, 000}.
- R3: In a register-form word with 27 ≤ v and bits 10:5 not all ones, p = 5×bit5 + (v − 27) and registers b and c get high parts p div 3 and p mod 3, with low bits 3:2 and 1:0. `regs_o` carries b, c in slots 0 and 1, `nregs_o` = 2, and `opcode_o` = {bits 15:11, 00, bit 4}.
- R4: When bits 10:5 are all ones and bits 3:2 are not 11, the word has one operand: register bits 3:0 goes in slot 0 and `opcode_o` = {bits 15:11, 00, bit 4}. When bits 3:2 are 11, the word has no operands and `opcode_o` = {bits 15:11, bit 4, bits 1:0}.
- R5: Forms 4 and 5 put register bits 9:6 in slot 0, give `nregs_o` = 1, take their immediate from bits 5:0, and set `opcode_o` = {00, bits 15:10}. Form 5 raises `illegal_o` when the register is 12 or above.
- R6: Form 6 takes its immediate from bits 9:0 and has no registers. A word with bits 15:10 = 111101 is form 9 and illegal.
- R7: An immediate prefix word makes the next immediate equal to (prefix bits << own width) | own bits, where the own width is 6 or 10. Consecutive immediate prefixes concatenate, the earlier word landing higher.
- R8: Reset and every valid word that is not a legal prefix clear both pending prefixes. Cycles with `insn_valid_i` low leave them unchanged. Without a pending prefix, `long_o` is 0 and the immediate is the word's own bits.
- R9: A word following a pending operand prefix sets `long_o`. Its own operands occupy the first slots and the prefix's two or three registers follow. `nregs_o` is the sum, and `long_xop_o` is bit 4 of a two-operand prefix (0 for a three-operand one). Prefix words themselves report no registers.
- R10: An operand prefix whose field is a one- or zero-operand pattern is form 9 and illegal. A pending operand prefix consumed by an immediate form, or a pending immediate prefix consumed by a register form, raises `illegal_o` on the consuming word.
- R11: For register forms with at least one operand, `shamt_o` maps the last register field c: 0 to 8 give themselves, 9 gives 16, 10 gives 24 and 11 gives 32. In every other case `shamt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| insn_valid_i | input | 1 | Instruction word present this cycle |
| insn_i | input | 16 | Instruction halfword |
| form_o | output | 4 | Operand form code |
| opcode_o | output | 8 | Widened opcode |
| nregs_o | output | 3 | Number of valid register slots |
| regs_o | output | 24 | Six 4-bit register slots, slot i at bits 4i+3:4i |
| imm_o | output | IMM_W | Immediate, prefix-extended |
| shamt_o | output | 6 | Shift amount mapped from field c |
| long_o | output | 1 | Operand prefix was merged |
| long_xop_o | output | 1 | Extra opcode bit from the operand prefix |
| illegal_o | output | 1 | Word is illegal in its context |

## Verification
The bench encodes every legal three-register triple and two-register pair with its own base-3 and bi-quinary packing, then decodes each one. A slip in the mod-5 split or in the quotient bit would swap registers in the upper half of the pair range. A wrong base-3 weight would corrupt registers 4 to 11. The boundary between zero-operand and one-operand words, and the register 11/12 limit on the restricted immediate form, catch comparisons that are off by one. The prefix tests chain two immediate prefixes, insert invalid gaps, clear a prefix with a plain word and apply reset mid-prefix. A design that shifted by the wrong width, kept stale prefix bits, or forgot to clear state would show the wrong immediate or a spurious merged-operand flag.

// File: rtl/insn16_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the 16-bit instruction decoder.
// Assumes 4-bit register indices and an 11-bit packed operand field.
package insn16_pkg;

    localparam int REG_W      = 4;
    localparam int MAX_OPS    = 6;
    localparam int FLD_W      = 11;
    localparam int PFX_IMM_W  = 10;
    localparam int SHORT_IMMW = 6;
    localparam int LONG_IMMW  = 10;

    typedef enum logic [3:0] {
        FORM_R3      = 4'd0,
        FORM_R2      = 4'd1,
        FORM_R1      = 4'd2,
        FORM_R0      = 4'd3,
        FORM_RI16    = 4'd4,
        FORM_RI12    = 4'd5,
        FORM_I10     = 4'd6,
        FORM_PFX_IMM = 4'd7,
        FORM_PFX_OPR = 4'd8,
        FORM_BAD     = 4'd9
    } form_e;

    typedef enum logic [1:0] {
        ARITY_3 = 2'd0,
        ARITY_2 = 2'd1,
        ARITY_1 = 2'd2,
        ARITY_0 = 2'd3
    } arity_e;

    // Integer divide by three for values 0..8.
    function automatic logic [1:0] tri_hi(input logic [3:0] v);
        if (v >= 4'd6)      return 2'd2;
        else if (v >= 4'd3) return 2'd1;
        else                return 2'd0;
    endfunction

    // Number of operands carried by a packed field of the given arity.
    function automatic logic [1:0] ops_of(input arity_e a);
        case (a)
            ARITY_3: return 2'd3;
            ARITY_2: return 2'd2;
            ARITY_1: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // Map a small register-field constant to its shift amount.
    function automatic logic [5:0] shift_of(input logic [3:0] c);
        case (c)
            4'd9:    return 6'd16;
            4'd10:   return 6'd24;
            4'd11:   return 6'd32;
            4'd12, 4'd13, 4'd14, 4'd15: return 6'd0;
            default: return {2'b00, c};
        endcase
    endfunction

endpackage

// File: rtl/insn16_regfield.sv
`timescale 1ns/1ps
// Unpacks an 11-bit register-operand field into arity, minor opcode
// bits and up to three register numbers (a, b, c).
// Assumes: field bits 10:6 are the base-3 selector, bits 5:0 carry the
// low register bits or the one/zero-operand payload. Purely combinational.
module insn16_regfield
    import insn16_pkg::*;
(
    input  logic [FLD_W-1:0] fld_i,
    output arity_e           arity_o,
    output logic [2:0]       minor_o,
    output logic [REG_W-1:0] ra_o,
    output logic [REG_W-1:0] rb_o,
    output logic [REG_W-1:0] rc_o
);

    logic [4:0] sel;
    logic [4:0] rem;
    logic [3:0] pair;
    logic [1:0] hi_a;
    logic [1:0] hi_b;
    logic [1:0] hi_c;

    assign sel = fld_i[10:6];

    // Split the selector into register high parts and pick the arity.
    always_comb begin
        arity_o = ARITY_3;
        minor_o = 3'd0;
        ra_o    = '0;
        rb_o    = '0;
        rc_o    = '0;
        hi_a    = 2'd0;
        hi_b    = 2'd0;
        hi_c    = 2'd0;
        rem     = 5'd0;
        pair    = 4'd0;
        if (sel < 5'd27) begin
            hi_a    = (sel >= 5'd18) ? 2'd2 : ((sel >= 5'd9) ? 2'd1 : 2'd0);
            rem     = sel - 5'(9 * hi_a);
            hi_b    = tri_hi(rem[3:0]);
            hi_c    = 2'(rem - 5'(3 * hi_b));
            ra_o    = {hi_a, fld_i[5:4]};
            rb_o    = {hi_b, fld_i[3:2]};
            rc_o    = {hi_c, fld_i[1:0]};
        end else if (&fld_i[10:5]) begin
            if (fld_i[3:2] == 2'b11) begin
                arity_o = ARITY_0;
                minor_o = {fld_i[4], fld_i[1:0]};
            end else begin
                arity_o = ARITY_1;
                minor_o = {2'b00, fld_i[4]};
                rc_o    = fld_i[3:0];
            end
        end else begin
            arity_o = ARITY_2;
            minor_o = {2'b00, fld_i[4]};
            pair    = 4'((fld_i[5] ? 5 : 0) + (32'(sel) - 27));
            hi_b    = tri_hi(pair);
            hi_c    = 2'(pair - 4'(3 * hi_b));
            rb_o    = {hi_b, fld_i[3:2]};
            rc_o    = {hi_c, fld_i[1:0]};
        end
    end

endmodule

// File: rtl/insn16_prefix_state.sv
`timescale 1ns/1ps
// Holds the two pending-prefix states between instruction words.
// Assumes: the caller asserts at most the loads that apply to a valid
// word and asserts clear_i for every valid word that is not a prefix.
module insn16_prefix_state
    import insn16_pkg::*;
#(
    parameter int IMM_W = 32
)(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             imm_load_i,
    input  logic             opr_load_i,
    input  logic             clear_i,
    input  logic [PFX_IMM_W-1:0] imm_bits_i,
    input  logic [FLD_W-1:0] opr_fld_i,
    output logic             imm_pend_o,
    output logic [IMM_W-1:0] imm_acc_o,
    output logic             opr_pend_o,
    output logic [FLD_W-1:0] opr_fld_o
);

    logic [IMM_W-1:0] acc_next;

    // Earlier prefix bits move up, the newest ten land at the bottom.
    always_comb begin
        if (imm_pend_o)
            acc_next = (imm_acc_o << PFX_IMM_W) | IMM_W'(imm_bits_i);
        else
            acc_next = IMM_W'(imm_bits_i);
    end

    // Register the pending prefixes; reset and plain words clear them.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clear_i) begin
            imm_pend_o <= 1'b0;
            imm_acc_o  <= '0;
            opr_pend_o <= 1'b0;
            opr_fld_o  <= '0;
        end else begin
            if (imm_load_i) begin
                imm_pend_o <= 1'b1;
                imm_acc_o  <= acc_next;
            end
            if (opr_load_i) begin
                opr_pend_o <= 1'b1;
                opr_fld_o  <= opr_fld_i;
            end
        end
    end

endmodule

// File: rtl/insn16_decode.sv
`timescale 1ns/1ps
// Top of the 16-bit instruction decoder. Classifies the word by its top
// bits, unpacks register fields, merges pending prefixes and flags
// illegal words. Decode outputs follow insn_i in the same cycle.
// Assumes: outputs are only meaningful while insn_valid_i is high.
module insn16_decode
    import insn16_pkg::*;
#(
    parameter int IMM_W   = 32,
    parameter int NUM_GPR = 12
)(
    input  logic                     clk_i,
    input  logic                     rst_n_i,
    input  logic                     insn_valid_i,
    input  logic [15:0]              insn_i,
    output logic [3:0]               form_o,
    output logic [7:0]               opcode_o,
    output logic [2:0]               nregs_o,
    output logic [MAX_OPS*REG_W-1:0] regs_o,
    output logic [IMM_W-1:0]         imm_o,
    output logic [5:0]               shamt_o,
    output logic                     long_o,
    output logic                     long_xop_o,
    output logic                     illegal_o
);

    localparam int NSRC = 2;

    logic [3:0]       top4;
    logic             is_reg;
    form_e            form;
    logic             imm_load;
    logic             opr_load;
    logic             pfx_clear;
    logic             imm_pend;
    logic             opr_pend;
    logic [IMM_W-1:0] imm_acc;
    logic [FLD_W-1:0] opr_fld_q;

    logic [FLD_W-1:0] fld_src [NSRC];
    arity_e           ar      [NSRC];
    logic [2:0]       mn      [NSRC];
    logic [REG_W-1:0] ra      [NSRC];
    logic [REG_W-1:0] rb      [NSRC];
    logic [REG_W-1:0] rc      [NSRC];
    logic [REG_W-1:0] ops     [NSRC][3];
    logic [1:0]       nops    [NSRC];

    assign fld_src[0] = insn_i[10:0];
    assign fld_src[1] = opr_fld_q;

    // One unpacker for the current word, one for the stored operand prefix.
    for (genvar g = 0; g < NSRC; g++) begin : g_unpack
        insn16_regfield u_field (
            .fld_i   (fld_src[g]),
            .arity_o (ar[g]),
            .minor_o (mn[g]),
            .ra_o    (ra[g]),
            .rb_o    (rb[g]),
            .rc_o    (rc[g])
        );

        // Left-align the decoded operands of this source into an ordered list.
        always_comb begin
            nops[g] = ops_of(ar[g]);
            ops[g][0] = '0;
            ops[g][1] = '0;
            ops[g][2] = '0;
            case (ar[g])
                ARITY_3: begin
                    ops[g][0] = ra[g];
                    ops[g][1] = rb[g];
                    ops[g][2] = rc[g];
                end
                ARITY_2: begin
                    ops[g][0] = rb[g];
                    ops[g][1] = rc[g];
                end
                ARITY_1: ops[g][0] = rc[g];
                default: ;
            endcase
        end
    end

    insn16_prefix_state #(.IMM_W(IMM_W)) u_pfx (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .imm_load_i (imm_load),
        .opr_load_i (opr_load),
        .clear_i    (pfx_clear),
        .imm_bits_i (insn_i[9:0]),
        .opr_fld_i  (insn_i[10:0]),
        .imm_pend_o (imm_pend),
        .imm_acc_o  (imm_acc),
        .opr_pend_o (opr_pend),
        .opr_fld_o  (opr_fld_q)
    );

    assign top4   = insn_i[15:12];
    assign is_reg = (top4[3:2] == 2'b00) || (top4 == 4'b0100) ||
                    (top4[3:2] == 2'b10) || (top4 == 4'b1100);

    // Main classification: form, opcode, immediate, flags and prefix control.
    always_comb begin
        form       = FORM_BAD;
        opcode_o   = {2'b00, insn_i[15:10]};
        imm_o      = '0;
        shamt_o    = 6'd0;
        long_o     = 1'b0;
        long_xop_o = 1'b0;
        illegal_o  = 1'b0;
        imm_load   = 1'b0;
        opr_load   = 1'b0;
        if (is_reg) begin
            case (ar[0])
                ARITY_3: form = FORM_R3;
                ARITY_2: form = FORM_R2;
                ARITY_1: form = FORM_R1;
                default: form = FORM_R0;
            endcase
            opcode_o   = {insn_i[15:11], mn[0]};
            long_o     = opr_pend;
            long_xop_o = opr_pend && (|mn[1]);
            shamt_o    = (nops[0] != 2'd0) ? shift_of(rc[0]) : 6'd0;
            illegal_o  = imm_pend;
        end else if (top4 == 4'b0101 || top4 == 4'b0110 || top4 == 4'b0111) begin
            form      = (top4 == 4'b0111) ? FORM_RI12 : FORM_RI16;
            imm_o     = imm_pend ? ((imm_acc << SHORT_IMMW) | IMM_W'(insn_i[5:0]))
                                 : IMM_W'(insn_i[5:0]);
            illegal_o = opr_pend ||
                        ((top4 == 4'b0111) && (32'(insn_i[9:6]) >= NUM_GPR));
        end else if (top4 == 4'b1101 || top4 == 4'b1110) begin
            form      = FORM_I10;
            imm_o     = imm_pend ? ((imm_acc << LONG_IMMW) | IMM_W'(insn_i[9:0]))
                                 : IMM_W'(insn_i[9:0]);
            illegal_o = opr_pend;
        end else if (top4 == 4'b1111 && insn_i[11]) begin
            if (ar[0] == ARITY_3 || ar[0] == ARITY_2) begin
                form     = FORM_PFX_OPR;
                opr_load = insn_valid_i;
            end else begin
                illegal_o = 1'b1;
            end
        end else if (top4 == 4'b1111 && !insn_i[10]) begin
            form     = FORM_PFX_IMM;
            imm_load = insn_valid_i;
        end else begin
            illegal_o = 1'b1;
        end
        form_o    = form;
        pfx_clear = insn_valid_i && !imm_load && !opr_load;
    end

    // Fill register slots: current operands first, then the prefix operands.
    always_comb begin
        logic [1:0] cur_n;
        logic [1:0] pfx_n;
        regs_o = '0;
        cur_n  = 2'd0;
        pfx_n  = 2'd0;
        if (is_reg) begin
            cur_n = nops[0];
            pfx_n = opr_pend ? nops[1] : 2'd0;
        end else if (form == FORM_RI16 || form == FORM_RI12) begin
            regs_o[REG_W-1:0] = insn_i[9:6];
        end
        for (int i = 0; i < MAX_OPS; i++) begin
            if (i < 32'(cur_n))
                regs_o[i*REG_W +: REG_W] = ops[0][i % 3];
            else if (i - 32'(cur_n) < 32'(pfx_n))
                regs_o[i*REG_W +: REG_W] = ops[1][(i - 32'(cur_n)) % 3];
        end
        if (form == FORM_RI16 || form == FORM_RI12)
            nregs_o = 3'd1;
        else
            nregs_o = 3'(cur_n) + 3'(pfx_n);
    end

endmodule

// File: rtl/insn16_decode_chk.sv
`timescale 1ns/1ps
// Property checker for insn16_decode, attached with bind below.
// Assumes: outputs are judged only while insn_valid_i is high.
module insn16_decode_chk
    import insn16_pkg::*;
#(
    parameter int IMM_W   = 32,
    parameter int NUM_GPR = 12
)(
    input logic                     clk_i,
    input logic                     rst_n_i,
    input logic                     insn_valid_i,
    input logic [9:0]               insn_lo_i,
    input logic [3:0]               form_i,
    input logic [2:0]               nregs_i,
    input logic [MAX_OPS*REG_W-1:0] regs_i,
    input logic [IMM_W-1:0]         imm_i,
    input logic [5:0]               shamt_i,
    input logic                     long_i,
    input logic                     illegal_i
);

    logic slot_over;
    logic reg_form;

    // Any reported register slot at or above the general register count.
    always_comb begin
        slot_over = 1'b0;
        for (int i = 0; i < MAX_OPS; i++)
            if (i < 32'(nregs_i) && 32'(regs_i[i*REG_W +: REG_W]) >= NUM_GPR)
                slot_over = 1'b1;
    end

    assign reg_form = (form_i == FORM_R3) || (form_i == FORM_R2) ||
                      (form_i == FORM_R1) || (form_i == FORM_R0);

    // R2 R3: packed register fields only ever yield general registers.
    assert_gpr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (insn_valid_i && reg_form) |-> !slot_over);

    // R9: prefix words report no registers and never merge.
    assert_prefix_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (insn_valid_i && (form_i == FORM_PFX_IMM || form_i == FORM_PFX_OPR))
        |-> (nregs_i == 3'd0 && !long_i));

    // R9: a merged word is a register form with at least two operands.
    assert_long_shape_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (insn_valid_i && long_i) |-> (reg_form && nregs_i >= 3'd2));

    // R11: shift amounts only come from register forms and never exceed 32.
    assert_shamt_src_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (insn_valid_i && shamt_i != 6'd0) |-> (reg_form && form_i != FORM_R0 && shamt_i <= 6'd32));

    // R6: the undefined prefix pattern is always flagged.
    assert_bad_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (insn_valid_i && form_i == FORM_BAD) |-> illegal_i);

    // R7: the prefix word directly before a 10-bit immediate lands just above it.
    if (IMM_W >= 20) begin : g_chain
        assert_pfx_above_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (insn_valid_i && form_i == FORM_I10 &&
             $past(insn_valid_i) && $past(form_i) == FORM_PFX_IMM && $past(rst_n_i))
            |-> (imm_i[19:10] == $past(insn_lo_i)));
    end

endmodule

bind insn16_decode insn16_decode_chk #(.IMM_W(IMM_W), .NUM_GPR(NUM_GPR)) u_chk (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .insn_valid_i (insn_valid_i),
    .insn_lo_i    (insn_i[9:0]),
    .form_i       (form_o),
    .nregs_i      (nregs_o),
    .regs_i       (regs_o),
    .imm_i        (imm_o),
    .shamt_i      (shamt_o),
    .long_i       (long_o),
    .illegal_i    (illegal_o)
);

// File: tb/insn16_decode_tb.sv
`timescale 1ns/1ps
// Directed bench for insn16_decode: one task per scenario.
module insn16_decode_tb_top;

    localparam int IMM_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid = 1'b0;
    logic [15:0]       insn = 16'd0;
    logic [3:0]        form;
    logic [7:0]        opcode;
    logic [2:0]        nregs;
    logic [23:0]       regs;
    logic [IMM_W-1:0]  imm;
    logic [5:0]        shamt;
    logic              long_f;
    logic              long_x;
    logic              illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    insn16_decode #(.IMM_W(IMM_W), .NUM_GPR(12)) dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .insn_valid_i (valid),
        .insn_i       (insn),
        .form_o       (form),
        .opcode_o     (opcode),
        .nregs_o      (nregs),
        .regs_o       (regs),
        .imm_o        (imm),
        .shamt_o      (shamt),
        .long_o       (long_f),
        .long_xop_o   (long_x),
        .illegal_o    (illegal)
    );

    // Count one check and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present a word at the falling edge and let combinational outputs settle.
    task automatic apply(input logic [15:0] w, input bit v);
        @(negedge clk);
        insn  = w;
        valid = v;
        #1;
    endtask

    function automatic logic [15:0] enc3(input logic [4:0] maj, input int a, input int b, input int c);
        int v;
        v = 9 * (a / 4) + 3 * (b / 4) + (c / 4);
        return {maj, 5'(v), 2'(a % 4), 2'(b % 4), 2'(c % 4)};
    endfunction

    function automatic logic [15:0] enc2(input logic [4:0] maj, input bit x, input int b, input int c);
        int p;
        p = 3 * (b / 4) + (c / 4);
        return {maj, 5'(p % 5 + 27), 1'(p / 5), x, 2'(b % 4), 2'(c % 4)};
    endfunction

    function automatic logic [15:0] enc1(input logic [4:0] maj, input bit x, input int r);
        return {maj, 6'h3F, x, 4'(r)};
    endfunction

    function automatic logic [15:0] enc0(input logic [4:0] maj, input bit x, input int s);
        return {maj, 6'h3F, x, 2'b11, 2'(s)};
    endfunction

    function automatic logic [5:0] exp_shift(input int c);
        if (c == 9)  return 6'd16;
        if (c == 10) return 6'd24;
        if (c == 11) return 6'd32;
        return 6'(c);
    endfunction

    // R8: reset leaves no prefix pending, including one loaded just before reset.
    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply(16'hD155, 1'b1);
        chk("R8", "imm after reset", 64'(imm), 64'h155);
        chk("R8", "long after reset", 64'(long_f), 64'd0);
        apply({6'b111100, 10'h3A5}, 1'b1);
        @(negedge clk);
        valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(16'hD155, 1'b1);
        chk("R8", "imm after mid-prefix reset", 64'(imm), 64'h155);
        chk("R6", "form I10", 64'(form), 64'd6);
    endtask

    // R2: every legal register triple decodes back to itself.
    task automatic t_three;
        for (int a = 0; a < 12; a++)
            for (int b = 0; b < 12; b++)
                for (int c = 0; c < 12; c++) begin
                    apply(enc3(5'b00011, a, b, c), 1'b1);
                    chk("R2", "triple", {form, nregs, opcode, regs},
                        {4'd0, 3'd3, 5'b00011, 3'b000, 12'd0, 4'(c), 4'(b), 4'(a)});
                end
    endtask

    // R3: every legal register pair and both extra opcode bits.
    task automatic t_two;
        for (int x = 0; x < 2; x++)
            for (int b = 0; b < 12; b++)
                for (int c = 0; c < 12; c++) begin
                    apply(enc2(5'b10010, 1'(x), b, c), 1'b1);
                    chk("R3", "pair", {form, nregs, opcode, regs},
                        {4'd1, 3'd2, 5'b10010, 2'b00, 1'(x), 16'd0, 4'(c), 4'(b)});
                end
    endtask

    // R4 R11: one-operand words with shift mapping, then zero-operand words.
    task automatic t_one_zero;
        for (int x = 0; x < 2; x++)
            for (int r = 0; r < 12; r++) begin
                apply(enc1(5'b00101, 1'(x), r), 1'b1);
                chk("R4", "single", {form, nregs, opcode, regs},
                    {4'd2, 3'd1, 5'b00101, 2'b00, 1'(x), 20'd0, 4'(r)});
                chk("R11", "shift map", 64'(shamt), 64'(exp_shift(r)));
            end
        for (int x = 0; x < 2; x++)
            for (int s = 0; s < 4; s++) begin
                apply(enc0(5'b11000, 1'(x), s), 1'b1);
                chk("R4", "zero-op", {form, nregs, opcode, shamt},
                    {4'd3, 3'd0, 5'b11000, 1'(x), 2'(s), 6'd0});
            end
    endtask

    // R5: register plus 6-bit immediate, wide and restricted variants.
    task automatic t_reg_imm;
        apply({6'b010110, 4'd15, 6'h2A}, 1'b1);
        chk("R5", "ri16 r15", {form, nregs, regs[3:0], 8'(imm), illegal, opcode},
            {4'd4, 3'd1, 4'd15, 8'h2A, 1'b0, 8'b00010110});
        apply({6'b011100, 4'd11, 6'h3F}, 1'b1);
        chk("R5", "ri12 r11 legal", {form, regs[3:0], 8'(imm), illegal},
            {4'd5, 4'd11, 8'h3F, 1'b0});
        apply({6'b011101, 4'd12, 6'h01}, 1'b1);
        chk("R5", "ri12 r12 illegal", {form, illegal}, {4'd5, 1'b1});
        chk("R11", "ri shift zero", 64'(shamt), 64'd0);
    endtask

    // R6 R1: ten-bit immediates and the undefined prefix pattern.
    task automatic t_imm10_bad;
        apply({6'b111010, 10'h3FF}, 1'b1);
        chk("R6", "i10", {form, nregs, 16'(imm), illegal}, {4'd6, 3'd0, 16'h3FF, 1'b0});
        apply({6'b111101, 10'h000}, 1'b1);
        chk("R6", "bad prefix", {form, illegal}, {4'd9, 1'b1});
        apply({4'b0100, 12'h000}, 1'b1);
        chk("R1", "0100 is register form", 64'(form), 64'd0);
        apply({4'b1100, 12'hFFF}, 1'b1);
        chk("R1", "1100 zero-op", 64'(form), 64'd3);
    endtask

    // R7 R8 R10: immediate prefix placement, chaining, gaps and clearing.
    task automatic t_pfix;
        apply({6'b111100, 10'h2AB}, 1'b1);
        chk("R7", "pfix word", {form, nregs, illegal}, {4'd7, 3'd0, 1'b0});
        apply({6'b110100, 10'h155}, 1'b1);
        chk("R7", "single pfix on i10", 64'(imm), 64'hAAD55);
        apply({6'b111100, 10'h001}, 1'b1);
        apply({6'b111100, 10'h002}, 1'b1);
        apply({6'b010100, 4'd3, 6'h05}, 1'b1);
        chk("R7", "chained pfix on ri", 64'(imm), 64'h10085);
        apply({6'b111100, 10'h3FF}, 1'b1);
        apply(16'h0000, 1'b0);
        apply(16'h0000, 1'b0);
        apply({6'b110100, 10'h000}, 1'b1);
        chk("R8", "pfix held across gap", 64'(imm), 64'hFFC00);
        apply({6'b111100, 10'h001}, 1'b1);
        apply(enc3(5'b00001, 1, 2, 3), 1'b1);
        chk("R10", "pfix on register form", 64'(illegal), 64'd1);
        apply({6'b110100, 10'h007}, 1'b1);
        chk("R8", "pfix cleared", {32'(imm), 31'd0, illegal}, {32'h7, 31'd0, 1'b0});
    endtask

    // R9 R10 R8: operand prefix merging, rejection and clearing.
    task automatic t_eopr;
        apply(enc3(5'b11111, 1, 5, 9), 1'b1);
        chk("R9", "opr prefix word", {form, nregs, long_f, illegal}, {4'd8, 3'd0, 1'b0, 1'b0});
        apply(enc3(5'b00011, 10, 11, 0), 1'b1);
        chk("R9", "six operands", {long_f, long_x, nregs, regs},
            {1'b1, 1'b0, 3'd6, 4'd9, 4'd5, 4'd1, 4'd0, 4'd11, 4'd10});
        apply(enc3(5'b00011, 2, 2, 2), 1'b1);
        chk("R8", "opr prefix consumed", {long_f, nregs}, {1'b0, 3'd3});
        apply(enc2(5'b11111, 1'b1, 7, 3), 1'b1);
        apply(enc0(5'b00100, 1'b0, 2), 1'b1);
        chk("R9", "prefix-only operands", {form, long_f, long_x, nregs, regs[7:0]},
            {4'd3, 1'b1, 1'b1, 3'd2, 4'd3, 4'd7});
        apply(enc1(5'b11111, 1'b0, 3), 1'b1);
        chk("R10", "one-op pattern prefix", {form, illegal}, {4'd9, 1'b1});
        apply(enc1(5'b00100, 1'b0, 4), 1'b1);
        chk("R10", "rejected prefix not kept", {long_f, nregs}, {1'b0, 3'd1});
        apply(enc3(5'b11111, 0, 0, 0), 1'b1);
        apply({6'b110100, 10'h001}, 1'b1);
        chk("R10", "opr prefix on i10", 64'(illegal), 64'd1);
        apply(enc2(5'b11111, 1'b0, 11, 8), 1'b1);
        apply(16'h0000, 1'b0);
        apply(enc1(5'b00100, 1'b1, 4), 1'b1);
        chk("R9", "merge after gap", {long_f, nregs, regs[11:0]},
            {1'b1, 3'd3, 4'd8, 4'd11, 4'd4});
    endtask

    initial begin
        t_reset();
        t_three();
        t_two();
        t_one_zero();
        t_reg_imm();
        t_imm10_bad();
        t_pfix();
        t_eopr();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: an expired run is a failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule